// File: doc/BRIEF.md
# 64-bit Integer Arithmetic and Logic Unit

This block is the execute-stage arithmetic and logic unit of a 64-bit RISC-V style integer datapath. It takes two 64-bit operands and a 4-bit operation code. It returns a 64-bit result through combinational logic only. There is no clock, no reset and no stored state. The result follows the inputs in the same cycle.

The unit covers the following operations:
- addition and subtraction
- bitwise AND, OR and XOR
- logical left shift, logical right shift and arithmetic right shift
- an upper-constant mode that builds a value from a 20-bit field

The caller chooses whether operand B comes from a register or from a sign-extended immediate, outside this block. The house state-machine style has no state to act on here. Instead, the operation code is a named enumeration decoded by one `unique case`, and there are no states or transitions.

Operation codes (`op_sel`):
- 0 add
- 1 subtract
- 2 AND
- 3 OR
- 4 XOR
- 5 shift left logical
- 6 shift right logical
- 7 shift right arithmetic
- 8 upper constant
- 9 to 15 unused

Top module: `rv64_alu_core`

## Requirements
- R1: Code 0 returns op_a + op_b modulo 2^64. A carry out of bit 63 is dropped.
- R2: Code 1 returns op_a − op_b modulo 2^64. Borrows wrap around.
- R3: Codes 2, 3 and 4 return op_a & op_b, op_a | op_b and op_a ^ op_b respectively. Each bit position is computed independently.
- R4: Code 5 shifts op_a toward bit 63 by op_b[5:0] places and fills with zeros. A shift amount of 0 returns op_a unchanged.
- R5: Code 6 shifts op_a toward bit 0 by op_b[5:0] places and fills the vacated upper bits with zeros.
- R6: Code 7 shifts op_a toward bit 0 by op_b[5:0] places and fills the vacated upper bits with copies of op_a[63].
- R7: For codes 5, 6 and 7, op_b[63:6] has no effect on the result.
- R8: Code 8 places op_b[19:0] in result[31:12] and sets result[11:0] to zero. result[63:32] are copies of result[31], so 0x12345 gives 0x0000000012345000. op_b[63:20] and op_a have no effect.
- R9: Codes 9 through 15 return zero.
- R10: The result depends only on the present inputs. A change of op_sel and operands at the same instant gives the new result with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand; also the value that is shifted |
| op_b | input | 64 | Second operand; low 6 bits are the shift amount, low 20 bits are the upper-constant field |
| op_sel | input | 4 | Operation code, see table above |
| result | output | 64 | Combinational result |

## Verification
Two functions can act in the same cycle: the operation code and both operands can change at one instant. One case is a switch from a shift to the upper-constant mode. In that switch, op_b's low six bits set the shift amount before the change and the low twenty bits set the constant after it. The bench changes code and operands together in one step, with no clock edge between them. It compares the settled result against a model built from native operators for the new code only. Operands with large upper bits in op_b are used, so that a leak of the shift-amount field or of the upper bits shows up as a mismatch.

// File: rtl/rv64_alu_pkg.sv
package rv64_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHRL = 4'd6,
        OP_SHRA = 4'd7,
        OP_UPC  = 4'd8
    } alu_op_e;

endpackage

// File: rtl/rv64_alu_addsub.sv
module rv64_alu_addsub #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            do_sub,
    output logic [XLEN-1:0] sum
);

    logic [XLEN-1:0] b_eff;

    always_comb begin
        b_eff = b ^ {XLEN{do_sub}};
        sum   = a + b_eff + {{(XLEN-1){1'b0}}, do_sub};
    end

    // R2
    always_comb begin
        if (do_sub) begin
            sub_inverse_chk: assert (sum + b == a)
                else $error("difference plus subtrahend differs from minuend");
        end
    end

endmodule

// File: rtl/rv64_alu_logic.sv
module rv64_alu_logic #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] and_res,
    output logic [XLEN-1:0] or_res,
    output logic [XLEN-1:0] xor_res
);

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign and_res[i] = a[i] & b[i];
        assign or_res[i]  = a[i] | b[i];
        assign xor_res[i] = a[i] ^ b[i];
    end

    // R3
    always_comb begin
        bitwise_cross_chk: assert (or_res == (and_res ^ xor_res))
            else $error("OR result inconsistent with AND and XOR results");
    end

endmodule

// File: rtl/rv64_alu_shift.sv
module rv64_alu_shift #(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amt,
    input  logic            to_left,
    input  logic            arith,
    output logic [XLEN-1:0] res
);

    logic [XLEN-1:0] src;
    logic [XLEN-1:0] stg [SHW+1];
    logic            fill;

    function automatic logic [XLEN-1:0] flip(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int k = 0; k < XLEN; k++) r[k] = v[XLEN-1-k];
        return r;
    endfunction

    always_comb begin
        src  = to_left ? flip(a) : a;
        fill = arith & ~to_left & a[XLEN-1];
    end

    assign stg[0] = src;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int DIST = 1 << i;
        assign stg[i+1] = amt[i] ? {{DIST{fill}}, stg[i][XLEN-1:DIST]} : stg[i];
    end

    assign res = to_left ? flip(stg[SHW]) : stg[SHW];

    // R4
    always_comb begin
        if (amt == '0) begin
            zero_shift_chk: assert (res == a)
                else $error("shift by zero altered the operand");
        end
    end

    // R6
    always_comb begin
        if (arith && !to_left && a[XLEN-1]) begin
            sign_fill_chk: assert (res[XLEN-1])
                else $error("arithmetic right shift lost the sign bit");
        end
    end

endmodule

// File: rtl/rv64_alu_core.sv
module rv64_alu_core
    import rv64_alu_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int UPC_W   = 20,
    parameter int UPC_LSB = 12
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [3:0]      op_sel,
    output logic [XLEN-1:0] result
);

    localparam int SHW     = $clog2(XLEN);
    localparam int UPC_TOP = UPC_LSB + UPC_W;

    alu_op_e         op;
    logic [XLEN-1:0] sum_res;
    logic [XLEN-1:0] and_res;
    logic [XLEN-1:0] or_res;
    logic [XLEN-1:0] xor_res;
    logic [XLEN-1:0] sh_res;
    logic [XLEN-1:0] upc_res;
    logic            do_sub;
    logic            to_left;
    logic            arith;

    always_comb begin
        op      = alu_op_e'(op_sel);
        do_sub  = (op == OP_SUB);
        to_left = (op == OP_SHL);
        arith   = (op == OP_SHRA);
        upc_res = {{(XLEN-UPC_TOP){op_b[UPC_W-1]}}, op_b[UPC_W-1:0], {UPC_LSB{1'b0}}};
    end

    rv64_alu_addsub #(.XLEN(XLEN)) addsub_i (
        .a      (op_a),
        .b      (op_b),
        .do_sub (do_sub),
        .sum    (sum_res)
    );

    rv64_alu_logic #(.XLEN(XLEN)) logic_i (
        .a       (op_a),
        .b       (op_b),
        .and_res (and_res),
        .or_res  (or_res),
        .xor_res (xor_res)
    );

    rv64_alu_shift #(.XLEN(XLEN)) shift_i (
        .a       (op_a),
        .amt     (op_b[SHW-1:0]),
        .to_left (to_left),
        .arith   (arith),
        .res     (sh_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:          result = sum_res;
            OP_AND:                  result = and_res;
            OP_OR:                   result = or_res;
            OP_XOR:                  result = xor_res;
            OP_SHL, OP_SHRL, OP_SHRA: result = sh_res;
            OP_UPC:                  result = upc_res;
            default:                 result = '0;
        endcase
    end

    // R8
    always_comb begin
        if (op_sel == 4'd8) begin
            upc_low_zero_chk: assert (result[UPC_LSB-1:0] == '0 &&
                                      result[XLEN-1:UPC_TOP-1] == {(XLEN-UPC_TOP+1){result[UPC_TOP-1]}})
                else $error("upper-constant result has bad low or extended bits");
        end
    end

    // R9
    always_comb begin
        if (op_sel > 4'd8) begin
            unused_code_chk: assert (result == '0)
                else $error("unused operation code gave a nonzero result");
        end
    end

endmodule

// File: tb/rv64_alu_core_tb.sv
module rv64_alu_core_tb_top;

    logic        clk = 1'b0;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic [3:0]  op_sel;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    rv64_alu_core dut_i (
        .op_a   (op_a),
        .op_b   (op_b),
        .op_sel (op_sel),
        .result (result)
    );

    function automatic logic [63:0] model(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b);
        case (c)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << b[5:0];
            4'd6: return a >> b[5:0];
            4'd7: return $unsigned($signed(a) >>> b[5:0]);
            4'd8: return {{32{b[19]}}, b[19:0], 12'h000};
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic apply(input string req, input logic [3:0] c, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp;
        op_sel = c; op_a = a; op_b = b;
        #2;
        exp = model(c, a, b);
        n_chk++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s code=%0d a=%h b=%h got=%h exp=%h", req, c, a, b, result, exp);
        end
    endtask

    task automatic t_idle;
        apply("R9 idle zero", 4'd0, 64'h0, 64'h0);
    endtask

    task automatic t_add;
        apply("R1 add", 4'd0, 64'd5, 64'd7);
        apply("R1 add wrap", 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    endtask

    task automatic t_sub;
        apply("R2 sub", 4'd1, 64'd20, 64'd7);
        apply("R2 sub borrow", 4'd1, 64'd0, 64'd1);
    endtask

    task automatic t_logic;
        for (int c = 2; c <= 4; c++)
            apply("R3 bitwise", c[3:0], 64'hF0F0_1234_AAAA_0F0F, 64'h0FF0_4321_5555_FF00);
    endtask

    task automatic t_shift;
        apply("R4 shl by 0", 4'd5, 64'hDEAD_BEEF_0123_4567, 64'd0);
        apply("R4 shl by 3", 4'd5, 64'h8000_0000_0000_0003, 64'd3);
        apply("R4 shl by 63", 4'd5, 64'h3, 64'd63);
        apply("R5 shrl by 63", 4'd6, 64'h8000_0000_0000_0000, 64'd63);
        apply("R5 shrl neg", 4'd6, 64'hF000_0000_0000_0010, 64'd4);
        apply("R6 shra neg", 4'd7, 64'hF000_0000_0000_0010, 64'd4);
        apply("R6 shra neg 63", 4'd7, 64'h8000_0000_0000_0000, 64'd63);
        apply("R6 shra pos", 4'd7, 64'h7000_0000_0000_0010, 64'd4);
    endtask

    task automatic t_shamt_mask;
        apply("R7 shl upper b ignored", 4'd5, 64'h1, 64'hFFFF_FFFF_FFFF_FFC1);
        apply("R7 shrl upper b ignored", 4'd6, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0140);
        apply("R7 shra upper b ignored", 4'd7, 64'h8000_0000_0000_0000, 64'hABCD_0000_0000_0080);
    endtask

    task automatic t_upc;
        apply("R8 upc example", 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0001_2345);
        apply("R8 upc sign", 4'd8, 64'h0, 64'hFFFF_0000_000F_EDCB);
        apply("R8 upc upper b ignored", 4'd8, 64'h1234, 64'h7777_7777_7770_0001);
    endtask

    task automatic t_unused;
        for (int c = 9; c <= 15; c++)
            apply("R9 unused code", c[3:0], 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_same_instant;
        apply("R10 shift then", 4'd7, 64'h8123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFF8_0025);
        apply("R10 upc now", 4'd8, 64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFF8_0025);
        apply("R10 sub now", 4'd1, 64'h0, 64'hFFFF_FFFF_FFF8_0025);
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [63:0] a;
            logic [63:0] b;
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b = lfsr;
            lfsr = next_rand(lfsr);
            apply("R10 random all ops", lfsr[3:0], a, b);
        end
    endtask

    initial begin
        op_a = '0; op_b = '0; op_sel = '0;
        @(negedge clk);
        t_idle();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_shamt_mask();
        t_upc();
        t_unused();
        t_same_instant();
        t_random();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule